// File: doc/BRIEF.md
# Software Interrupt Pending/Claim Controller

This block lets software running on one processor raise an interrupt on another. It is arranged like a platform-level interrupt controller, with one difference: a pending bit can be set only by a register write, and never by a hardware wire. Source IDs run from 1 to NSRC. By software convention, the interrupt aimed at hart h uses source ID h+1. Each of the NHART target contexts has its own enable words, its own priority threshold, its own claim/complete register and one interrupt output line.

The block sits behind a simple 32-bit register bus. The bus has a byte address, a write strobe, a read strobe, write data, and read data that is returned one cycle later. A context services an interrupt in three steps:
1. It reads its claim register to learn which source won arbitration.
2. It handles that source.
3. It writes the same ID back to the same register to mark completion.

Between the claim and the completion the source is in service and is not delivered to any context.

Top module: `swint_ctrl`

## Requirements
- R1: After reset, every priority, enable word, pending bit, in-service flag and threshold reads zero, every irq_o bit is low, and a claim read returns 0.
- R2: The priority of source n (1..NSRC) sits at byte offset 4*n and holds PRIO_W bits, read back zero-extended. Offset 0x0 always reads 0 and ignores writes.
- R3: Pending word k sits at offset 0x1000+4*k, and its bit b is source 32*k+b. Writing a 1 to a bit sets it and writing a 0 has no effect. Bit 0, and any bit above NSRC, always reads 0.
- R4: The enable word k of context c sits at offset 0x2000+0x80*c+4*k and reads back as written, except that bit 0 and bits above NSRC read 0.
- R5: The threshold of context c sits at offset 0x200000+0x1000*c, holds PRIO_W bits and resets to 0. A source is eligible for context c only if its priority is strictly greater than that threshold.
- R6: A read of the claim register of context c (offset 0x200004+0x1000*c) returns the eligible source with the highest priority, with ties going to the lowest ID. It returns 0 if no source is eligible. A source is eligible when it is pending, enabled for c, not in service, and above the threshold.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and marks it in service in the same cycle. While it is in service, the source raises no interrupt and cannot be claimed by any context, even if it is pending again.
- R8: A write of an in-service ID to any context's claim register clears that source's in-service flag. A write of an ID that is not in service, or that is out of range, changes nothing.
- R9: irq_o[c] is a registered OR over the sources eligible for context c. It reflects a state change on the clock edge after the edge that made the change.
- R10: Read data appears on bus_rdata on the cycle after bus_re. Unmapped addresses, including contexts at or beyond NHART, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 22 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of a claim register has side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| irq_o | output | NHART | One interrupt line per context |

## Verification
The bench fills the pending array with equal-priority sources to check that ties go to the lowest ID. A design that scans in the wrong direction, or that replaces the winner on an equal priority, returns the highest ID instead. The bench sets the threshold equal to a source's priority to check the strictly-above comparison; a design that uses greater-or-equal would still assert the line and grant the source. The bench raises a source again while it is in service and sends a completion carrying an unrelated ID. A design without in-service blocking would grant the source twice, and a design that does not filter completions would release the wrong source. Finally, the bench checks that a claim through one context silences another context that shares the source, and that writing zeros to the pending word leaves the set bits in place.

// File: rtl/swint_pkg.sv
package swint_pkg;

  localparam int unsigned ADDR_W = 22;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_PEND,
    REG_ENAB,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [9:0] ctx;
    logic [9:0] idx;
  } reg_dec_t;

  // Address map decode; range checks against the parameters happen in the top.
  function automatic reg_dec_t map_decode(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    logic [ADDR_W-1:0] off;
    d = '0;
    d.kind = REG_NONE;
    off = a - ADDR_W'(22'h2000);
    if (a[21]) begin
      d.ctx = {1'b0, a[20:12]};
      if (a[11:0] == 12'h000) d.kind = REG_THR;
      else if (a[11:0] == 12'h004) d.kind = REG_CLAIM;
    end else if (a[21:12] == 10'd1) begin
      d.kind = REG_PEND;
      d.idx  = a[11:2];
    end else if (a[21:13] != 9'd0) begin
      if (off[21:17] == 5'd0) begin
        d.kind = REG_ENAB;
        d.ctx  = off[16:7];
        d.idx  = {5'd0, off[6:2]};
      end
    end else begin
      d.kind = REG_PRIO;
      d.idx  = a[11:2];
    end
    return d;
  endfunction

endpackage

// File: rtl/swint_arb.sv
module swint_arb #(
  parameter int unsigned NS1    = 9,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 4
) (
  input  logic [NS1-1:0]        elig_i,
  input  logic [NS1*PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]       id_o,
  output logic                  hit_o
);

  logic [PRIO_W-1:0] best;

  // Ascending scan; only a strictly larger priority replaces the winner,
  // so the lowest ID keeps a tie.
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    best  = '0;
    for (int n = 1; n < NS1; n++) begin
      if (elig_i[n] && (!hit_o || prio_i[n*PRIO_W +: PRIO_W] > best)) begin
        hit_o = 1'b1;
        id_o  = ID_W'(n);
        best  = prio_i[n*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/swint_srcstate.sv
module swint_srcstate #(
  parameter int unsigned VW   = 32,
  parameter int unsigned ID_W = 4,
  parameter logic [VW-1:0] SRC_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [VW-1:0]   set_vec,
  input  logic            claim_en,
  input  logic [ID_W-1:0] claim_id,
  input  logic            cmpl_en,
  input  logic [ID_W-1:0] cmpl_id,
  output logic [VW-1:0]   pend_o,
  output logic [VW-1:0]   insvc_o
);

  logic [VW-1:0] pend_q, insvc_q, pend_d, insvc_d;

  always_comb begin
    pend_d  = pend_q;
    insvc_d = insvc_q;
    if (set_en) pend_d = pend_d | (set_vec & SRC_MASK);
    if (claim_en) begin
      pend_d[claim_id]  = 1'b0;
      insvc_d[claim_id] = 1'b1;
    end
    if (cmpl_en && insvc_q[cmpl_id]) insvc_d[cmpl_id] = 1'b0;
    pend_d  = pend_d & SRC_MASK;
    insvc_d = insvc_d & SRC_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = insvc_q;

  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
    claim_en |=> (!pend_q[$past(claim_id)] && insvc_q[$past(claim_id)])); // R7

  AST_PEND_SET_ONLY: assert property (@(posedge clk) disable iff (rst)
    !claim_en |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

  AST_CMPL_FILTER: assert property (@(posedge clk) disable iff (rst)
    (cmpl_en && !claim_en && !insvc_q[cmpl_id]) |=> $stable(insvc_q)); // R8

endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int unsigned NSRC   = 8,
  parameter int unsigned NHART  = 4,
  parameter int unsigned PRIO_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NHART-1:0]     irq_o
);

  localparam int unsigned NS1   = NSRC + 1;
  localparam int unsigned NWORD = (NS1 + 31) / 32;
  localparam int unsigned VW    = NWORD * 32;
  localparam int unsigned ID_W  = $clog2(NS1);
  localparam logic [VW-1:0] SRC_MASK = ((VW'(1) << NS1) - VW'(1)) ^ VW'(1);

  reg_dec_t dec;
  logic     ctx_ok;
  assign dec    = map_decode(bus_addr);
  assign ctx_ok = dec.ctx < 10'(NHART);

  logic [PRIO_W-1:0]     prio_q [NS1];
  logic [NS1*PRIO_W-1:0] prio_flat;
  logic [VW-1:0]         ena_q  [NHART];
  logic [PRIO_W-1:0]     thr_q  [NHART];
  logic [VW-1:0]         pend, insvc;
  logic [VW-1:0]         elig   [NHART];
  logic [ID_W-1:0]       arb_id [NHART];
  logic [NHART-1:0]      arb_hit;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NS1; n++) prio_q[n] <= '0;
      for (int c = 0; c < NHART; c++) begin
        ena_q[c] <= '0;
        thr_q[c] <= '0;
      end
    end else if (bus_we) begin
      for (int n = 1; n < NS1; n++)
        if (dec.kind == REG_PRIO && dec.idx == 10'(n)) prio_q[n] <= bus_wdata[PRIO_W-1:0];
      for (int c = 0; c < NHART; c++) begin
        if (dec.kind == REG_THR && dec.ctx == 10'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
        for (int w = 0; w < NWORD; w++)
          if (dec.kind == REG_ENAB && dec.ctx == 10'(c) && dec.idx == 10'(w))
            ena_q[c][w*32 +: 32] <= bus_wdata & SRC_MASK[w*32 +: 32];
      end
    end
  end

  always_comb
    for (int n = 0; n < NS1; n++) prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n];

  // Per-context eligibility and arbitration
  for (genvar c = 0; c < NHART; c++) begin : g_ctx
    always_comb begin
      elig[c] = '0;
      for (int n = 1; n < NS1; n++)
        elig[c][n] = pend[n] & ena_q[c][n] & ~insvc[n] & (prio_q[n] > thr_q[c]);
    end

    swint_arb #(.NS1(NS1), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .elig_i (elig[c][NS1-1:0]),
      .prio_i (prio_flat),
      .id_o   (arb_id[c]),
      .hit_o  (arb_hit[c])
    );

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
      arb_hit[c] |-> elig[c][arb_id[c]]); // R6
  end

  // Claim and completion
  logic            claim_fire, cmpl_fire, set_fire;
  logic [ID_W-1:0] claim_id;
  logic [VW-1:0]   set_vec;

  always_comb begin
    claim_fire = 1'b0;
    claim_id   = '0;
    for (int c = 0; c < NHART; c++)
      if (dec.ctx == 10'(c)) begin
        claim_fire = bus_re && dec.kind == REG_CLAIM && arb_hit[c];
        claim_id   = arb_id[c];
      end
  end

  assign cmpl_fire = bus_we && dec.kind == REG_CLAIM && ctx_ok &&
                     bus_wdata != 32'd0 && bus_wdata <= 32'(NSRC);
  assign set_fire  = bus_we && dec.kind == REG_PEND && dec.idx < 10'(NWORD);
  assign set_vec   = VW'(bus_wdata) << (dec.idx * 32);

  swint_srcstate #(.VW(VW), .ID_W(ID_W), .SRC_MASK(SRC_MASK)) u_state (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_fire),
    .set_vec  (set_vec),
    .claim_en (claim_fire),
    .claim_id (claim_id),
    .cmpl_en  (cmpl_fire),
    .cmpl_id  (bus_wdata[ID_W-1:0]),
    .pend_o   (pend),
    .insvc_o  (insvc)
  );

  // Read mux and registered outputs
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    unique case (dec.kind)
      REG_PRIO:
        for (int n = 1; n < NS1; n++)
          if (dec.idx == 10'(n)) rd_val = 32'(prio_q[n]);
      REG_PEND:
        for (int w = 0; w < NWORD; w++)
          if (dec.idx == 10'(w)) rd_val = pend[w*32 +: 32];
      REG_ENAB:
        for (int c = 0; c < NHART; c++)
          for (int w = 0; w < NWORD; w++)
            if (dec.ctx == 10'(c) && dec.idx == 10'(w)) rd_val = ena_q[c][w*32 +: 32];
      REG_THR:
        for (int c = 0; c < NHART; c++)
          if (dec.ctx == 10'(c)) rd_val = 32'(thr_q[c]);
      REG_CLAIM:
        for (int c = 0; c < NHART; c++)
          if (dec.ctx == 10'(c) && arb_hit[c]) rd_val = 32'(arb_id[c]);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= '0;
    end else begin
      bus_rdata <= bus_re ? rd_val : 32'd0;
      for (int c = 0; c < NHART; c++) irq_o[c] <= |elig[c];
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == '0) |=> bus_rdata == 32'd0); // R2

  AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (bus_re && dec.kind == REG_CLAIM && !claim_fire) |=> bus_rdata == 32'd0); // R6

endmodule

// File: tb/swint_ctrl_tb.sv
`timescale 1ns/1ps
module swint_ctrl_tb;

  localparam int NH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NH-1:0] irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  swint_ctrl #(.NSRC(8), .NHART(NH), .PRIO_W(3)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_re(re),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [21:0] a_prio(int n);  return 22'(4*n); endfunction
  function automatic logic [21:0] a_ena(int c);   return 22'(32'h2000 + 32'h80*c); endfunction
  function automatic logic [21:0] a_thr(int c);   return 22'(32'h200000 + 32'h1000*c); endfunction
  function automatic logic [21:0] a_clm(int c);   return 22'(32'h200004 + 32'h1000*c); endfunction
  localparam logic [21:0] A_PEND = 22'h1000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [21:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rdchk("R1 prio1 reset", a_prio(1), 32'h0);
    rdchk("R1 pending reset", A_PEND, 32'h0);
    rdchk("R1 enable c0 reset", a_ena(0), 32'h0);
    rdchk("R1 r5_threshold reset", a_thr(0), 32'h0);
    rdchk("R1 claim reset", a_clm(0), 32'h0);
  endtask

  task automatic t_prio();
    wr(a_prio(1), 32'hFFFF_FFFF);
    rdchk("R2 prio1 width", a_prio(1), 32'h7);
    wr(22'h0, 32'hFF);
    rdchk("R2 reserved offset", 22'h0, 32'h0);
    wr(a_prio(8), 32'h5);
    rdchk("R2 prio8", a_prio(8), 32'h5);
    wr(a_prio(9), 32'h7);
    rdchk("R10 prio beyond NSRC", a_prio(9), 32'h0);
  endtask

  task automatic t_pend();
    wr(A_PEND, 32'h5);
    rdchk("R3 bit0 ignored", A_PEND, 32'h4);
    wr(A_PEND, 32'h8);
    rdchk("R3 zero bits keep", A_PEND, 32'hC);
    wr(A_PEND, 32'h200);
    rdchk("R3 above NSRC", A_PEND, 32'hC);
    settle();
    chk("R9 no enables no irq", 32'(irq), 32'h0);
  endtask

  task automatic t_enable();
    wr(a_ena(1), 32'hFFFF_FFFF);
    rdchk("R4 enable mask", a_ena(1), 32'h1FE);
    wr(a_ena(1), 32'h0);
    rdchk("R4 enable clear", a_ena(1), 32'h0);
  endtask

  task automatic t_arb();
    wr(a_prio(2), 32'h5);
    wr(a_prio(3), 32'h5);
    wr(a_ena(0), 32'h1FE);
    wr(A_PEND, 32'h102);
    settle();
    chk("R9 irq0 raised", 32'(irq), 32'h1);
    rdchk("R6 highest prio wins", a_clm(0), 32'd1);
    rdchk("R7 claim clears pend", A_PEND, 32'h10C);
    rdchk("R6 tie lowest id", a_clm(0), 32'd2);
    wr(a_thr(0), 32'h5);
    settle();
    chk("R5 equal threshold masks", 32'(irq), 32'h0);
    rdchk("R5 claim under threshold", a_clm(0), 32'd0);
    wr(a_thr(0), 32'h4);
    rdchk("R6 next tie", a_clm(0), 32'd3);
    rdchk("R6 last source", a_clm(0), 32'd8);
    rdchk("R6 empty claim", a_clm(0), 32'd0);
  endtask

  task automatic t_insvc();
    wr(A_PEND, 32'h2);
    rdchk("R7 repend visible", A_PEND, 32'h2);
    settle();
    chk("R7 in service no irq", 32'(irq), 32'h0);
    rdchk("R7 in service no claim", a_clm(0), 32'd0);
    wr(a_clm(0), 32'd1);
    settle();
    chk("R8 completion releases", 32'(irq), 32'h1);
    rdchk("R8 reclaim after completion", a_clm(0), 32'd1);
    wr(a_clm(0), 32'd6);
    wr(A_PEND, 32'h4);
    rdchk("R8 stray completion ignored", a_clm(0), 32'd0);
  endtask

  task automatic t_multi();
    wr(a_ena(2), 32'h8);
    wr(a_clm(2), 32'd3);
    wr(A_PEND, 32'h8);
    settle();
    chk("R9 shared source two lines", 32'(irq), 32'h5);
    rdchk("R6 claim via ctx2", a_clm(2), 32'd3);
    settle();
    chk("R7 other context silenced", 32'(irq), 32'h0);
    rdchk("R7 pending after multi", A_PEND, 32'h4);
  endtask

  task automatic t_unmapped();
    rdchk("R10 ctx beyond NHART", a_thr(5), 32'h0);
    rdchk("R10 enable beyond NHART", 22'h3000, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    t_reset();
    t_prio();
    t_pend();
    t_enable();
    t_arb();
    t_insvc();
    t_multi();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule